// File: doc/BRIEF.md
# Minutes-Seconds Elapsed Timer

This block counts elapsed time on three decimal digits: units of seconds, tens of seconds and minutes. It runs from 0:00 to 9:59 and then wraps to 0:00. Three digit stages form a chain. The units stage counts 0 to 9. The tens stage counts 0 to 5. The minutes stage counts 0 to 9. The wrap of each stage is a combinational enable for the next stage. All three stages change on the same system clock edge.

A tick generator inside the block divides the system clock to set the count rate. The input `fast_i` picks between two division ratios. The slow ratio gives the nominal one step per second. The fast ratio gives a faster rate for bring-up, about 7.5 steps per second. The tens stage wraps when the value it would load next has bits 2 and 1 both set, which is the pattern 0110. It loads 0 in that same cycle, so the output never shows 6. The same event advances the minutes stage. When the whole count wraps, a one-cycle pulse marks it. Seven-segment decoding of the digits is done outside this block.

Top module: `mmss_timer`

## Requirements
- R1: While `rst_ni` is low, all three digits read 0 and `rollover_o` reads 0, whatever `fast_i` does. After `rst_ni` rises, the first step comes after one full tick period.
- R2: With `fast_i` = 0, the count advances by exactly one step every DIV_SLOW clock cycles, and only on those cycles.
- R3: With `fast_i` = 1, the count advances by exactly one step every DIV_FAST clock cycles. A change of `fast_i` made right after a step takes effect for the next period.
- R4: `sec_ones_o` counts 0 to 9. When it wraps from 9 to 0, `sec_tens_o` advances on the same clock edge.
- R5: `sec_tens_o` never exceeds 5. When a carry arrives at 5, it loads 0 on the same clock edge (the would-be value 0110 is detected from bits 2 and 1), and `min_o` advances on that same edge.
- R6: `min_o` counts 0 to 9 in steps of one minute.
- R7: On the step from 9:59, all digits become 0:00, and `rollover_o` is 1 for exactly the one cycle that follows that clock edge. It is 0 at all other times.
- R8: Between tick steps, all three digits hold their values. Every digit changes only on a tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low; holds the count at 0:00 |
| fast_i | input | 1 | 1 selects the DIV_FAST tick period, 0 selects DIV_SLOW |
| sec_ones_o | output | 4 | BCD units-of-seconds digit |
| sec_tens_o | output | 4 | BCD tens-of-seconds digit (0 to 5) |
| min_o | output | 4 | BCD minutes digit |
| rollover_o | output | 1 | One-cycle pulse after the 9:59 to 0:00 wrap |

## Verification
The bench runs the chain at the slow rate for the first ten steps. This shows the tick period and the units wrap into tens. It then switches to the fast rate and sweeps through every value up to and past 9:59. This covers each tens wrap from 5 to 0 with its minute carry, and the full wrap with its pulse, which must not appear at any other step. It samples partway through tick periods to tell a correct period from an early or doubled step. It also applies reset in the middle of a count and holds it across several periods. This separates a true hold at zero from a count that keeps running underneath and then resumes from a stale phase.

// File: rtl/mmss_timer_pkg.sv
package mmss_timer_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned N_STAGES = 3;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // index 0: seconds units, 1: seconds tens, 2: minutes
  function automatic int unsigned stage_last(input int unsigned idx);
    return (idx == 1) ? 5 : 9;
  endfunction

  function automatic bit stage_bit_detect(input int unsigned idx);
    return idx == 1;
  endfunction
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int unsigned DIV_SLOW = 100_000_000,
  parameter int unsigned DIV_FAST = 13_333_333
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1 = fast_i ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
  // >= so a switch to a shorter period mid-count still wraps
  assign tick_o = (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r2_cnt_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r2_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/timer_bcd_stage.sv
module timer_bcd_stage
  import mmss_timer_pkg::*;
#(
  parameter int unsigned LAST       = 9,
  parameter bit          BIT_DETECT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output bcd_t q_o,
  output logic wrap_o
);
  bcd_t q_q;
  bcd_t inc;
  logic hit;

  assign inc = q_q + 1'b1;

  generate
    if (BIT_DETECT) begin : g_bits
      // would-be value 0110 recognised from its two middle bits
      assign hit = inc[2] & inc[1];
    end else begin : g_cmp
      assign hit = (inc == DIGIT_W'(LAST + 1));
    end
  endgenerate

  assign wrap_o = en_i & hit;
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (en_i) q_q <= hit ? '0 : inc;
  end

  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= DIGIT_W'(LAST));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

  a_r4_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> q_o == '0);

  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_o) |=> q_o == $past(q_o) + 1'b1);
endmodule

// File: rtl/mmss_timer.sv
module mmss_timer
  import mmss_timer_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 100_000_000,
  parameter int unsigned DIV_FAST = 13_333_333
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fast_i,
  output logic [3:0] sec_ones_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_o,
  output logic       rollover_o
);
  logic                tick;
  logic [N_STAGES:0]   en;
  logic [N_STAGES-1:0] wrap;
  bcd_t                digit [N_STAGES];
  logic                roll_q;

  timer_tick_gen #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_FAST(DIV_FAST)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fast_i(fast_i),
    .tick_o(tick)
  );

  assign en[0] = tick;

  generate
    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      timer_bcd_stage #(
        .LAST      (stage_last(i)),
        .BIT_DETECT(stage_bit_detect(i))
      ) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en[i]),
        .q_o   (digit[i]),
        .wrap_o(wrap[i])
      );
      assign en[i+1] = wrap[i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) roll_q <= 1'b0;
    else         roll_q <= en[N_STAGES];
  end

  assign sec_ones_o = digit[0];
  assign sec_tens_o = digit[1];
  assign min_o      = digit[2];
  assign rollover_o = roll_q;

  a_r7_roll_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |-> (sec_ones_o == 4'd0 && sec_tens_o == 4'd0 && min_o == 4'd0));

  a_r7_roll_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |=> !rollover_o);

  a_r8_all_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable({sec_ones_o, sec_tens_o, min_o}));

  a_r6_min_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_o <= 4'd9);
endmodule

// File: tb/mmss_timer_test.sv
module mmss_timer_test;
  localparam int SLOW = 8;
  localparam int FAST = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fast_i = 1'b0;
  logic [3:0] sec_ones_o, sec_tens_o, min_o;
  logic       rollover_o;

  int checks = 0;
  int errors = 0;
  int secs   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mmss_timer #(.DIV_SLOW(SLOW), .DIV_FAST(FAST)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .fast_i    (fast_i),
    .sec_ones_o(sec_ones_o),
    .sec_tens_o(sec_tens_o),
    .min_o     (min_o),
    .rollover_o(rollover_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_count(input string req, input bit exp_roll);
    chk(sec_ones_o == 4'(secs % 10), req, "sec_ones", sec_ones_o, secs % 10);
    chk(sec_tens_o == 4'((secs / 10) % 6), req, "sec_tens", sec_tens_o, (secs / 10) % 6);
    chk(min_o == 4'(secs / 60), req, "min", min_o, secs / 60);
    chk(rollover_o == exp_roll, "R7", "rollover", rollover_o, exp_roll);
    chk(sec_tens_o <= 4'd5, "R5", "tens bound", sec_tens_o, 5);
  endtask

  // starts on a negedge right after a step edge; skip = edges already spent
  task automatic step_tick(input int lim, input int skip, input string req);
    repeat (lim - skip) @(negedge clk);
    secs = (secs + 1) % 600;
    chk_count(req, secs == 0);
  endtask

  task automatic t_reset_state;
    repeat (4) @(negedge clk);
    fast_i = 1'b1;
    repeat (5) @(negedge clk);
    chk_count("R1", 1'b0);
    fast_i = 1'b0;
    rst_ni = 1'b1;
    repeat (SLOW - 1) @(negedge clk);
    chk_count("R1", 1'b0);  // R8: no step before a full period
    step_tick(SLOW, SLOW - 1, "R2");
  endtask

  task automatic t_units_slow;
    for (int k = 0; k < 9; k++) begin
      repeat (SLOW / 2) @(negedge clk);
      chk_count("R8", 1'b0);
      step_tick(SLOW, SLOW / 2, "R4");
    end
  endtask

  task automatic t_fast_rate;
    fast_i = 1'b1;
    repeat (FAST - 1) @(negedge clk);
    chk_count("R3", 1'b0);
    step_tick(FAST, FAST - 1, "R3");
    while (secs != 65) step_tick(FAST, 0, "R5");
  endtask

  task automatic t_full_wrap;
    while (secs != 599) step_tick(FAST, 0, "R6");
    step_tick(FAST, 0, "R7");
    chk(rollover_o == 1'b1, "R7", "pulse at wrap", rollover_o, 1);
    @(negedge clk);
    chk(rollover_o == 1'b0, "R7", "pulse one cycle", rollover_o, 0);
    chk_count("R7", 1'b0);
    step_tick(FAST, 1, "R4");
  endtask

  task automatic t_reset_mid;
    for (int k = 0; k < 13; k++) step_tick(FAST, 0, "R4");
    @(negedge clk);
    rst_ni = 1'b0;
    secs = 0;
    #1;
    chk_count("R1", 1'b0);
    repeat (4 * FAST) @(negedge clk);
    chk_count("R1", 1'b0);
    rst_ni = 1'b1;
    repeat (FAST - 1) @(negedge clk);
    chk_count("R1", 1'b0);
    step_tick(FAST, FAST - 1, "R1");
    step_tick(FAST, 0, "R3");
  endtask

  initial begin
    t_reset_state();
    t_units_slow();
    t_fast_rate();
    t_full_wrap();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule